// File: doc/BRIEF.md
# NAND Flash Controller Register Front End

This block is the register face of a NAND flash controller, attached to a plain 32-bit read/write bus. It keeps a control word, two timing words and a status word, and it drives one level interrupt built from the status bits that software has left unmasked. Data movement, error correction and the flash pin sequencing all live elsewhere.

A command is launched in a fixed order. Software first sets the run bit in the control word, which raises the command-request flag in status. It then writes three times to the single command-buffer address. Those three writes are latched in order as command words 0, 1 and 2. After the third one the words are offered to a downstream cycle sequencer on a valid/ready pair. The sequencer reports its events back as a 12-bit pulse vector. Each pulse sets the matching sticky status bit, and the command-done pulse also drops the run bit.

Top module: `nfc_regfront`

## Requirements
- R1: After reset the control, timing and status registers read 0, except status bit 12, which reads 1. `irq_o` and `cmd_valid_o` are 0.
- R2: The control (0x00), timing-0 (0x04) and timing-1 (0x0C) registers read back the last value written. A read of an unmapped offset such as 0x40 returns 0.
- R3: A control write that changes the run bit (bit 28) from 0 to 1 sets status bit 0, the command request.
- R4: While run is set, the first three writes to offset 0x48 are latched as command words 0, 1 and 2. Word k appears on `cmd_words_o[32k+31:32k]`. In the cycle after the third write, `cmd_valid_o` is 1, and it falls after the first cycle in which `cmd_ready_i` is 1.
- R5: A write to 0x48 while run is clear is dropped, and so is a fourth or later write after the three words are held. A dropped write changes neither `cmd_words_o` nor `cmd_valid_o`.
- R6: Writing status (0x14) with a 1 in bit k (k in 11:0) clears bit k, and a 0 leaves it unchanged. If a hardware event sets the same bit in the same cycle, the set wins.
- R7: A 1 in `seq_evt_i[k]` sets status bit k. Bit 8 is command done, 10 page done, 11 flash ready, 4 double-bit error, 3 single-bit error, 2 write-data request and 1 read-data request.
- R8: `irq_o` is 1 exactly when some status bit k in 11:0 is set while control bit k is 0. A 1 in control bit k masks status bit k.
- R9: A `seq_evt_i[8]` pulse clears the run bit. Status bit 12 reads as the inverse of the run bit.
- R10: The command request (status bit 0) stays set after the three words are captured, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt, OR of the unmasked status bits |
| seq_evt_i | input | 12 | Event pulses from the sequencer; bit k sets status bit k |
| cmd_valid_o | output | 1 | Three command words are ready |
| cmd_ready_i | input | 1 | The sequencer takes the words |
| cmd_words_o | output | 96 | Command words 2, 1, 0, with word 0 in the low bits |

## Verification
The command path is exercised with three distinct words. This shows whether the capture order and the valid pulse are correct. Writes made before run is set, and a fourth write after capture, are checked to show that neither the words nor valid change. Status clearing is tried with an all-zero write and a single-bit write, which separates write-one-to-clear from plain overwrite. The same error event is raised under a masking and a non-masking control word, and a command-done pulse is checked for its side effect on the run bit.

// File: rtl/nfc_regfront_pkg.sv
package nfc_regfront_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_TIM0 = 8'h04;
  localparam logic [7:0] OFS_TIM1 = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_CMD  = 8'h48;
  localparam int unsigned RUN_BIT  = 28;
  localparam int unsigned DONE_BIT = 8;
  localparam int unsigned CREQ_BIT = 0;
endpackage

// File: rtl/nfc_ctrl_regs.sv
module nfc_ctrl_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              tim0_we_i,
  input  logic              tim1_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cmd_done_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] tim0_o,
  output logic [DATA_W-1:0] tim1_o,
  output logic              run_rise_o
);
  import nfc_regfront_pkg::*;

  logic [DATA_W-1:0] ctrl_q, tim0_q, tim1_q;

  assign run_rise_o = ctrl_we_i & wdata_i[RUN_BIT] & ~ctrl_q[RUN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tim0_q <= '0;
      tim1_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i;
      if (cmd_done_i) ctrl_q[RUN_BIT] <= 1'b0;  // hardware clear wins
      if (tim0_we_i) tim0_q <= wdata_i;
      if (tim1_we_i) tim1_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign tim0_o = tim0_q;
  assign tim1_o = tim1_q;

  assert_run_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> !ctrl_q[RUN_BIT]);
  assert_run_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_rise_o && !cmd_done_i) |=> ctrl_q[RUN_BIT]);
endmodule

// File: rtl/nfc_status_irq.sv
module nfc_status_irq #(
  parameter int unsigned EVT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [EVT_W-1:0] clr_i,
  input  logic [EVT_W-1:0] mask_i,
  output logic [EVT_W-1:0] stat_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] stat_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_eff) | set_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_i);

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_eff & ~set_i) != '0) |=> ((stat_q & $past(clr_eff & ~set_i)) == '0));
  assert_set_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  assert_irq_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & ~mask_i) != '0) |=> (irq_o || !$stable(mask_i)));
endmodule

// File: rtl/nfc_cmd_capture.sv
module nfc_cmd_capture #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_WORDS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      run_i,
  input  logic                      run_rise_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      ready_i,
  output logic [N_WORDS*DATA_W-1:0] words_o,
  output logic                      valid_o
);
  localparam int unsigned CNT_W = $clog2(N_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_WORDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q, accept;

  assign accept = wr_i & run_i & (cnt_q < CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (run_rise_i) cnt_q <= '0;
    else if (accept)     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               word_q <= '0;
      else if (accept && cnt_q == CNT_W'(k))     word_q <= wdata_i;
    end
    assign words_o[k*DATA_W +: DATA_W] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          valid_q <= 1'b0;
    else if (accept && cnt_q == CNT_LAST) valid_q <= 1'b1;
    else if (ready_i)                     valid_q <= 1'b0;
  end

  assign valid_o = valid_q;

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  assert_valid_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && ready_i) |=> !valid_q);
  assert_idle_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !run_i) |=> $stable(words_o));
endmodule

// File: rtl/nfc_regfront.sv
module nfc_regfront #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned EVT_W   = 12,
  parameter int unsigned N_WORDS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_en_i,
  input  logic                      bus_we_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]         bus_wdata_i,
  output logic [DATA_W-1:0]         bus_rdata_o,
  output logic                      irq_o,
  input  logic [EVT_W-1:0]          seq_evt_i,
  output logic                      cmd_valid_o,
  input  logic                      cmd_ready_i,
  output logic [N_WORDS*DATA_W-1:0] cmd_words_o
);
  import nfc_regfront_pkg::*;

  localparam int unsigned PAD_W = DATA_W - EVT_W - 1;

  logic              wr;
  logic              ctrl_we, tim0_we, tim1_we, stat_we, cmd_we;
  logic [DATA_W-1:0] ctrl, tim0, tim1;
  logic [EVT_W-1:0]  stat, set_vec;
  logic              run_rise, run;

  assign wr      = bus_en_i & bus_we_i;
  assign ctrl_we = wr && bus_addr_i == ADDR_W'(OFS_CTRL);
  assign tim0_we = wr && bus_addr_i == ADDR_W'(OFS_TIM0);
  assign tim1_we = wr && bus_addr_i == ADDR_W'(OFS_TIM1);
  assign stat_we = wr && bus_addr_i == ADDR_W'(OFS_STAT);
  assign cmd_we  = wr && bus_addr_i == ADDR_W'(OFS_CMD);

  nfc_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .ctrl_we_i (ctrl_we),
    .tim0_we_i (tim0_we),
    .tim1_we_i (tim1_we),
    .wdata_i   (bus_wdata_i),
    .cmd_done_i(seq_evt_i[DONE_BIT]),
    .ctrl_o    (ctrl),
    .tim0_o    (tim0),
    .tim1_o    (tim1),
    .run_rise_o(run_rise)
  );

  assign run = ctrl[RUN_BIT];

  always_comb begin
    set_vec = seq_evt_i;
    set_vec[CREQ_BIT] = seq_evt_i[CREQ_BIT] | run_rise;
  end

  nfc_status_irq #(.EVT_W(EVT_W)) u_stat (
    .clk_i, .rst_ni,
    .set_i   (set_vec),
    .clr_we_i(stat_we),
    .clr_i   (bus_wdata_i[EVT_W-1:0]),
    .mask_i  (ctrl[EVT_W-1:0]),
    .stat_o  (stat),
    .irq_o   (irq_o)
  );

  nfc_cmd_capture #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_cmd (
    .clk_i, .rst_ni,
    .wr_i      (cmd_we),
    .run_i     (run),
    .run_rise_i(run_rise),
    .wdata_i   (bus_wdata_i),
    .ready_i   (cmd_ready_i),
    .words_o   (cmd_words_o),
    .valid_o   (cmd_valid_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADDR_W'(OFS_CTRL): bus_rdata_o = ctrl;
      ADDR_W'(OFS_TIM0): bus_rdata_o = tim0;
      ADDR_W'(OFS_TIM1): bus_rdata_o = tim1;
      ADDR_W'(OFS_STAT): bus_rdata_o = {{PAD_W{1'b0}}, ~run, stat};
      default:           bus_rdata_o = '0;
    endcase
  end

  assert_creq_on_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_rise && !stat_we) |=> stat[CREQ_BIT]);
endmodule

// File: tb/sim_nfc_regfront.sv
module sim_nfc_regfront;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  logic [11:0] evt = '0;
  logic        valid;
  logic        ready = 1'b1;
  logic [95:0] words;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  nfc_regfront u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .seq_evt_i(evt), .cmd_valid_o(valid),
    .cmd_ready_i(ready), .cmd_words_o(words)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h04, d); chk("R1 tim0", d, 0);
    rd(8'h14, d); chk("R1/R9 status", d, 32'h1000);
    chk("R1 irq", irq, 0);
    chk("R1 valid", valid, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h00, 32'h0000_0FFF);
    wr(8'h04, 32'h00A5_5A0F);
    wr(8'h0C, 32'hFFFF_00F3);
    rd(8'h00, d); chk("R2 ctrl", d, 32'h0000_0FFF);
    rd(8'h04, d); chk("R2 tim0", d, 32'h00A5_5A0F);
    rd(8'h0C, d); chk("R2 tim1", d, 32'hFFFF_00F3);
    rd(8'h40, d); chk("R2 unmapped", d, 0);
  endtask

  task automatic t_idle_drop;
    wr(8'h48, 32'hDEAD_0001);
    chk("R5 words idle", words, 0);
    chk("R5 valid idle", valid, 0);
  endtask

  task automatic t_handshake;
    logic [31:0] d;
    wr(8'h00, 32'h1000_0FFF);
    rd(8'h14, d); chk("R3 creq", d[0], 1);
    wr(8'h48, 32'h1111_0000);
    wr(8'h48, 32'h2222_0001);
    chk("R4 no early valid", valid, 0);
    wr(8'h48, 32'h3333_0002);
    chk("R4 valid", valid, 1);
    chk("R4 words", words, {32'h3333_0002, 32'h2222_0001, 32'h1111_0000});
    @(negedge clk);
    chk("R4 valid one cycle", valid, 0);
    wr(8'h48, 32'h4444_0003);
    chk("R5 fourth dropped", words, {32'h3333_0002, 32'h2222_0001, 32'h1111_0000});
    chk("R5 no valid", valid, 0);
    rd(8'h14, d); chk("R10 creq held", d[0], 1);
    wr(8'h14, 32'h0);
    rd(8'h14, d); chk("R6 zero write", d[0], 1);
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R6 w1c", d[0], 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    pulse(12'h008);
    rd(8'h14, d); chk("R7 sbe", d[3], 1);
    chk("R8 masked", irq, 0);
    wr(8'h00, 32'h1000_0FF7);
    chk("R8 unmasked", irq, 1);
    wr(8'h14, 32'h8);
    chk("R8 cleared", irq, 0);
    pulse(12'h100);
    rd(8'h00, d); chk("R9 run cleared", d[28], 0);
    rd(8'h14, d); chk("R7/R9 done", d, 32'h0000_1100);
    pulse(12'hFFE);
    rd(8'h14, d); chk("R7 all events", d, 32'h0000_1FFE);
    chk("R8 irq", irq, 1);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_idle_drop();
    t_handshake();
    t_events();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule